// File: doc/BRIEF.md
# Sized Shift and Rotate Unit

This unit is the shift and rotate stage of a microcoded integer datapath. It takes a source value, a shift count and an operation code. It computes one of seven shift or rotate results on the low 1, 2, 4 or 8 bytes of the source, then writes that result into the matching low bytes of the old destination value. The upper bytes of the old destination stay as they were. The count comes either from a register operand or from an 8-bit immediate. The operation is the same in both cases.

A sequencer asserts `in_valid` with one operation per cycle. The merged destination appears on `result`, with `out_valid`, one clock later. The two through-carry rotates take the incoming carry flag as an extra bit. Computing the flags after the operation is left to a neighbouring stage.

Top module: `shrot_unit`

## Requirements
- R1: Every operation accepted with `in_valid` high produces `out_valid` high and its `result` on the clock edge after the one that captures it. `out_valid` is low after any cycle without `in_valid`. A synchronous reset clears both `out_valid` and `result` to zero.
- R2: When `use_imm` is 1 the count is the zero-extended 8-bit `imm`, and otherwise it is `cnt_reg`. At size code 3 the count is then reduced to its low 6 bits. At every other size code it is reduced to its low 5 bits.
- R3: Size codes 0, 1, 2 and 3 select operand widths of 1, 2, 4 and 8 bytes. The result replaces only the low operand-width bytes of `old_dst`, and all higher bytes of `result` equal `old_dst`.
- R4: Op code 0 is a logical left shift. It fills with zeros, and a reduced count of at least the operand width gives zero.
- R5: Op code 1 is a logical right shift that fills the vacated upper bits of the operand with zeros. A reduced count of at least the width gives zero.
- R6: Op code 2 is an arithmetic right shift that fills with copies of the operand's top bit at its size. A count of at least the width gives all sign bits.
- R7: Op codes 3 (rotate left) and 4 (rotate right) rotate the operand by the reduced count modulo the width. A nonzero count that is a multiple of the width gives the source operand itself.
- R8: Op code 5 rotates the (width+1)-bit value {carry_in, operand} left by the reduced count modulo width+1. For a count n from 1 to the width, carry_in lands at bit n-1, and operand bits from the top fill the bits below it only when n exceeds 1.
- R9: Op code 6 rotates {carry_in, operand} right by the reduced count modulo width+1. For a count n from 1 to the width, carry_in lands at bit width-n, and operand bits wrap above it only when n exceeds 1.
- R10: For op codes 3, 4, 5 and 6, a reduced count of zero leaves the whole destination unchanged (`result` equals `old_dst`).
- R11: Op code 7 performs no operation, and `result` equals `old_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0..7) |
| size | input | 2 | Operand size code (1, 2, 4, 8 bytes) |
| src | input | 64 | Source value |
| cnt_reg | input | 64 | Count from a register operand |
| imm | input | 8 | Count from an immediate |
| use_imm | input | 1 | Select the immediate count |
| carry_in | input | 1 | Incoming carry flag |
| old_dst | input | 64 | Previous destination value |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Merged destination value |

## Verification
The bench sweeps every operation at every size over raw counts 0 to 63. It alternates the register and immediate count sources and puts junk in the count bits above the mask, so a unit that masked with the wrong width would shift or rotate by a large count where a small one was wanted. Counts that reach or pass the width catch shifters that wrap instead of clearing or sign-filling. Counts that are multiples of the width, or of width+1 for the carry rotates, catch wrong modulo handling. A count of exactly 1 on the carry rotates catches a carry placed one bit off. A rotate by zero catches a unit that writes the source back instead of keeping the destination. Random upper destination bytes expose any merge that zero-extends.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROTL = 3'd3,
    OP_ROTR = 3'd4,
    OP_RCL  = 3'd5,
    OP_RCR  = 3'd6,
    OP_NOP  = 3'd7
  } shrot_op_e;

  function automatic logic op_is_rotate(input shrot_op_e o);
    return (o == OP_ROTL) || (o == OP_ROTR) || (o == OP_RCL) || (o == OP_RCR);
  endfunction

endpackage

// File: rtl/shrot_count.sv
module shrot_count #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  parameter int SZ_W   = 2,
  parameter int SZ_MAX = 3,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] cnt_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic [SZ_W-1:0]   size,
  output logic [CNT_W-1:0]  cnt
);
  // Narrow operand sizes keep one count bit fewer than the widest size.
  always_comb begin
    cnt = use_imm ? imm[CNT_W-1:0] : cnt_reg[CNT_W-1:0];
    if (size != SZ_W'(SZ_MAX))
      cnt[CNT_W-1] = 1'b0;
  end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  shrot_op_e        op,
  input  logic [W-1:0]     src,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cf,
  output logic [W-1:0]     res
);
  localparam int LW = $clog2(W);

  // Reduce a count modulo W+1 for the through-carry rotates.
  function automatic int mod_w1(input logic [CNT_W-1:0] v);
    int t;
    t = int'(v);
    for (int i = 0; i < 8; i++)
      if (t >= W + 1) t = t - (W + 1);
    return t;
  endfunction

  logic         past_end;
  logic [LW-1:0] rot_amt;
  int           rc_amt;
  logic [W:0]   wide;

  always_comb begin
    past_end = int'(cnt) >= W;
    rot_amt  = cnt[LW-1:0];
    rc_amt   = mod_w1(cnt);
    wide     = {cf, src};
    unique case (op)
      OP_SHL:  res = past_end ? '0 : (src << cnt);
      OP_SHR:  res = past_end ? '0 : (src >> cnt);
      OP_SAR:  res = past_end ? {W{src[W-1]}} : W'($signed(src) >>> cnt);
      OP_ROTL: res = (src << rot_amt) | (src >> (W - int'(rot_amt)));
      OP_ROTR: res = (src >> rot_amt) | (src << (W - int'(rot_amt)));
      OP_RCL:  res = W'((wide << rc_amt) | (wide >> (W + 1 - rc_amt)));
      OP_RCR:  res = W'((wide >> rc_amt) | (wide << (W + 1 - rc_amt)));
      default: res = src;
    endcase
  end
endmodule

// File: rtl/shrot_merge.sv
module shrot_merge #(
  parameter int DATA_W = 64,
  parameter int SZ_W   = 2
) (
  input  logic [SZ_W-1:0]   size,
  input  logic              keep_old,
  input  logic [DATA_W-1:0] new_val,
  input  logic [DATA_W-1:0] old_dst,
  output logic [DATA_W-1:0] merged
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] byte_mask;

  always_comb begin
    for (int b = 0; b < NBYTES; b++)
      byte_mask[b*8 +: 8] = (b < (int'(1) << size)) ? 8'hFF : 8'h00;
    merged = keep_old ? old_dst : ((old_dst & ~byte_mask) | (new_val & byte_mask));
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1,
  localparam int SZ_W      = $clog2(NUM_SIZES),
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [SZ_W-1:0]   size,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] cnt_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] old_dst,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  shrot_op_e         op_e;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] lane_res [NUM_SIZES];
  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] merged;
  logic              keep_old;

  assign op_e = shrot_op_e'(op);

  shrot_count #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .SZ_W(SZ_W),
    .SZ_MAX(NUM_SIZES - 1), .CNT_W(CNT_W)
  ) u_count (
    .cnt_reg(cnt_reg), .imm(imm), .use_imm(use_imm), .size(size), .cnt(cnt)
  );

  // One lane per operand width, each sized to its own width.
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LANE_W = 8 << g;
    logic [LANE_W-1:0] lane_out;
    shrot_lane #(.W(LANE_W), .CNT_W(CNT_W)) u_lane (
      .op(op_e), .src(src[LANE_W-1:0]), .cnt(cnt), .cf(carry_in), .res(lane_out)
    );
    assign lane_res[g] = DATA_W'(lane_out);
  end

  assign picked   = lane_res[size];
  assign keep_old = (op_is_rotate(op_e) && (cnt == '0)) || (op_e == OP_NOP);

  shrot_merge #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_merge (
    .size(size), .keep_old(keep_old), .new_val(picked),
    .old_dst(old_dst), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  parameter int SZ_W   = 2,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [SZ_W-1:0]   size,
  input logic [DATA_W-1:0] src,
  input logic [DATA_W-1:0] cnt_reg,
  input logic [IMM_W-1:0]  imm,
  input logic              use_imm,
  input logic [DATA_W-1:0] old_dst,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  logic [CNT_W-1:0] eff;
  logic             rot_op;

  always_comb begin
    eff = use_imm ? imm[CNT_W-1:0] : cnt_reg[CNT_W-1:0];
    if (size != '1) eff[CNT_W-1] = 1'b0;
    rot_op = (op >= 3'd3) && (op <= 3'd6);
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_upper_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == '0) |=> result[DATA_W-1:8] == $past(old_dst[DATA_W-1:8]));

  p_shl_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && size == '0 && eff >= CNT_W'(8)) |=> result[7:0] == 8'h00);

  p_sar_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd2 && size == '0 && eff >= CNT_W'(8)) |=>
      result[7:0] == {8{$past(src[7])}});

  p_rot_zero_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rot_op && eff == '0) |=> result == $past(old_dst));

  p_nop_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd7) |=> result == $past(old_dst));
endmodule

bind shrot_unit shrot_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .SZ_W(SZ_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
  .src(src), .cnt_reg(cnt_reg), .imm(imm), .use_imm(use_imm),
  .old_dst(old_dst), .out_valid(out_valid), .result(result)
);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [63:0] src;
  logic [63:0] cnt_reg;
  logic [7:0]  imm;
  logic        use_imm;
  logic        carry_in;
  logic [63:0] old_dst;
  logic        out_valid;
  logic [63:0] result;

  typedef struct {
    logic [63:0] exp;
    string       tag;
    int          op;
    int          sz;
    int          cnt;
  } item_t;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;

  always #2 clk = ~clk;

  shrot_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .src(src), .cnt_reg(cnt_reg), .imm(imm), .use_imm(use_imm),
    .carry_in(carry_in), .old_dst(old_dst), .out_valid(out_valid), .result(result)
  );

  // Step-by-step behavioural model built from the requirements.
  function automatic logic [63:0] ref_model(int o, int sz, logic [63:0] craw,
                                            logic cf, logic [63:0] s, logic [63:0] od);
    int w;
    int n;
    logic [63:0] m;
    logic [63:0] a;
    logic c;
    logic b;
    w = 8 << sz;
    n = (sz == 3) ? int'(craw[5:0]) : int'(craw[4:0]);
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    a = s & m;
    c = cf;
    if (o == 7) return od;
    if (o >= 3 && n == 0) return od;
    for (int i = 0; i < n; i++) begin
      case (o)
        0: a = (a << 1) & m;
        1: a = a >> 1;
        2: begin b = a[w-1]; a = (a >> 1) | (64'(b) << (w - 1)); end
        3: begin b = a[w-1]; a = ((a << 1) & m) | 64'(b); end
        4: begin b = a[0]; a = (a >> 1) | (64'(b) << (w - 1)); end
        5: begin b = a[w-1]; a = ((a << 1) & m) | 64'(c); c = b; end
        default: begin b = a[0]; a = (a >> 1) | (64'(c) << (w - 1)); c = b; end
      endcase
    end
    return (od & ~m) | (a & m);
  endfunction

  function automatic string tag_of(int o, int sz, int n);
    string t;
    case (o)
      0: t = "R4";
      1: t = "R5";
      2: t = "R6";
      3, 4: t = "R7";
      5: t = "R8";
      6: t = "R9";
      default: t = "R11";
    endcase
    if (o >= 3 && o <= 6 && n == 0) t = "R10";
    if (sz < 3) t = {t, " R3"};
    return t;
  endfunction

  task automatic drive(int o, int sz, logic [63:0] creg, logic [7:0] im, logic ui,
                       logic [63:0] s, logic cf, logic [63:0] od, string extra);
    item_t it;
    logic [63:0] eff;
    @(negedge clk);
    in_valid = 1'b1; op = 3'(o); size = 2'(sz); cnt_reg = creg; imm = im;
    use_imm = ui; src = s; carry_in = cf; old_dst = od;
    eff = ui ? 64'(im) : creg;
    it.exp = ref_model(o, sz, eff, cf, s, od);
    it.op  = o; it.sz = sz; it.cnt = int'(eff[5:0]);
    it.tag = {tag_of(o, sz, (sz == 3) ? int'(eff[5:0]) : int'(eff[4:0])), extra};
    sb_q.push_back(it);
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle cycle: out_valid actual=%b expected=0", out_valid);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (rst === 1'b0 && out_valid === 1'b1) begin
      item_t it;
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R1 unexpected result: actual=%h expected=no output", result);
      end else begin
        it = sb_q.pop_front();
        if (result !== it.exp) begin
          n_fail++;
          $display("FAIL %s op=%0d sz=%0d cnt=%0d actual=%h expected=%h",
                   it.tag, it.op, it.sz, it.cnt, result, it.exp);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    report();
  end

  initial begin
    logic [63:0] s;
    logic [63:0] od;
    logic [63:0] cr;
    rst = 1'b1; in_valid = 1'b1; op = 3'd0; size = 2'd3; src = 64'hFFFF_FFFF_FFFF_FFFF;
    cnt_reg = 64'd1; imm = 8'd0; use_imm = 1'b0; carry_in = 1'b1; old_dst = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== 64'd0) begin
      n_fail++;
      $display("FAIL R1 reset state: actual=%b/%h expected=0/0", out_valid, result);
    end

    // Directed: count masking (R2).
    drive(0, 0, 64'd32, 8'd0, 1'b0, 64'h0000_0000_0000_00A5, 1'b0,
          64'h1111_2222_3333_4444, " R2 mask-to-5");
    drive(3, 3, 64'd0, 8'hC1, 1'b1, 64'h8000_0000_0000_0001, 1'b0,
          64'h0, " R2 imm-mask-to-6");
    drive(4, 1, 64'hFFFF_FFFF_FFFF_FFE0, 8'd0, 1'b0, 64'h1234, 1'b1,
          64'hABCD_EF01_2345_6789, " R2 high-junk");
    drive(8'd5 == 8'd5 ? 5 : 5, 0, 64'd0, 8'd1, 1'b1, 64'h0, 1'b1,
          64'hFFFF_FFFF_FFFF_FF00, " R8 cf-to-bit0");
    drive(6, 0, 64'd1, 8'd0, 1'b0, 64'h0, 1'b1, 64'h0, " R9 cf-to-top");
    drive(1, 1, 64'd3, 8'd0, 1'b0, 64'h8000, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, " R5 fill");
    idle_check();

    // Sweep: every op, every size, raw counts 0..63.
    for (int o = 0; o < 8; o++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int c = 0; c < 64; c++) begin
          s  = {$urandom, $urandom};
          s[(8 << sz) - 1] = c[2];
          od = {$urandom, $urandom};
          cr = {$urandom, $urandom};
          cr[5:0] = 6'(c);
          drive(o, sz, cr, {2'(c >> 4), 6'(c)}, 1'(c ^ sz), s, c[1], od, "");
        end
        idle_check();
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 results missing: actual=%0d pending expected=0", sb_q.size());
    end
    report();
  end
endmodule